// File: doc/BRIEF.md
# E1 Timeslot Source Selector with Code Insertion and Loopback

This block sits in the transmit path of an E1 framer. It sees one serial bit per transmit clock, with a frame of 32 eight-bit timeslots. A frame sync pulse marks the first bit of timeslot 0, which is channel 1. For every timeslot the block picks one of four sources and registers the chosen bit onto the transmit line. The sources are the backplane serial input, a shared idle byte, a per-channel code byte, or the receive-side serial stream. Inserted bytes are sent most significant bit first.

One bitmap of select bits does two jobs, depending on a mode flag. With the flag clear, a selected channel carries the shared idle byte. With the flag set, a selected channel carries the received data looped back. A second bitmap enables per-channel codes taken from a bank of 32 code bytes, and this bitmap wins over the first. All settings are loaded through a simple byte write port.

The received bits are taken in transmit timing without any realignment. The receive and transmit clocks and frame syncs must therefore be the same signals.

Top module: `e1_ts_insert`

## Requirements
- R1: While `rst` is high, `tx_ser` is 0 on the next clock. Reset clears both bitmaps, the idle byte and the mode flag, so after reset every channel carries `bp_ser` unchanged.
- R2: Channel n (1..32) owns bit (n-1) mod 8 of a bitmap byte. Its select bit is in the byte at address (n-1)/8 (addresses 0..3). Its enable bit is in the byte at address 4+(n-1)/8 (addresses 4..7).
- R3: The idle byte is at address 8, and bit 0 of the byte at address 9 is the mode flag. With the flag at 0, a channel whose select bit is 1 carries the idle byte. Idle bit 7 goes out in the first bit time of the timeslot and bit 0 in the last.
- R4: With the mode flag at 1, a channel whose select bit is 1 carries `rx_ser` bit for bit. A channel whose select bit is 0 carries `bp_ser`, whatever the mode.
- R5: Any set of channels may be selected, from none to all 32, in either mode.
- R6: The code for channel n is at address 32+(n-1). A channel whose enable bit is 1 carries its own code, MSB first, whatever its select bit and the mode flag.
- R7: A frame sync pulse makes the current bit the MSB of channel 1, even in the middle of a frame. Without a pulse, the bit position counts 0..255 and wraps to 0.
- R8: A channel's source and code are fixed by the register values present in its first bit time. A write during bits 1..7 of a timeslot takes effect from the next timeslot.
- R9: Each output bit appears on `tx_ser` one clock after the input bit of the same bit time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | One-clock pulse on the first bit of channel 1 |
| bp_ser | input | 1 | Backplane serial data |
| rx_ser | input | 1 | Receive-side serial data for loopback |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 8 | Register write data |
| tx_ser | output | 1 | Registered transmit serial data |

## Verification
Every output bit is due exactly one clock after the bit time it belongs to. This holds for backplane, loopback and inserted-code bits alike. The bench drives inputs at the falling edge. At the next falling edge it compares `tx_ser` with the value its reference model predicted for the cycle just driven.

A register write takes effect at the clock edge that captures it. The model therefore takes the timeslot decision from its register copy before that cycle's write. This places mid-slot writes in the following timeslot. Frame sync restarts and free-running wraps are modelled by the same bit position counter that the bench uses to generate syncs.

// File: rtl/e1ts_pkg.sv
package e1ts_pkg;
  typedef enum logic [1:0] {
    SRC_BP   = 2'd0,
    SRC_CODE = 2'd1,
    SRC_RX   = 2'd2
  } src_e;
endpackage

// File: rtl/e1ts_timing.sv
module e1ts_timing #(
  parameter int NCH       = 32,
  parameter int SLOT_BITS = 8,
  parameter int CHW       = $clog2(NCH),
  parameter int BW        = $clog2(SLOT_BITS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fsync,
  output logic [CHW-1:0] ch_idx,
  output logic [BW-1:0]  bit_idx,
  output logic           slot_start
);
  localparam int FRAME = NCH * SLOT_BITS;
  localparam int PW    = CHW + BW;
  localparam logic [PW-1:0] LAST = PW'(FRAME - 1);

  logic [PW-1:0] cnt_q, pos;

  always_comb begin
    if (fsync)              pos = '0;
    else if (cnt_q == LAST) pos = '0;
    else                    pos = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= LAST;
    else     cnt_q <= pos;
  end

  assign ch_idx     = pos[PW-1:BW];
  assign bit_idx    = pos[BW-1:0];
  assign slot_start = (bit_idx == '0);

  // R7: one cycle after a sync pulse the position is bit 1 of channel 1
  a_r7_after_sync: assert property (@(posedge clk) disable iff (rst)
    ($past(fsync) && !$past(rst) && !fsync) |-> (ch_idx == '0 && bit_idx == BW'(1)));
endmodule

// File: rtl/e1ts_regfile.sv
module e1ts_regfile #(
  parameter int NCH = 32,
  parameter int DW  = 8,
  parameter int CHW = $clog2(NCH),
  parameter int AW  = CHW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [CHW-1:0] rd_ch,
  output logic [NCH-1:0] sel_map,
  output logic [NCH-1:0] en_map,
  output logic [DW-1:0]  idle_code,
  output logic           loop_mode,
  output logic [DW-1:0]  code_rd
);
  localparam int NB        = NCH / DW;
  localparam int EN_BASE   = NB;
  localparam int IDLE_ADDR = 2 * NB;
  localparam int MODE_ADDR = 2 * NB + 1;

  logic [DW-1:0] sel_b [NB];
  logic [DW-1:0] en_b  [NB];
  logic [DW-1:0] idle_q;
  logic          mode_q;
  logic [DW-1:0] code_mem [NCH];

  wire code_hit = wr_en && wr_addr[AW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NB; i++) begin
        sel_b[i] <= '0;
        en_b[i]  <= '0;
      end
      idle_q <= '0;
      mode_q <= 1'b0;
    end else if (wr_en && !wr_addr[AW-1]) begin
      for (int i = 0; i < NB; i++) begin
        if (wr_addr == AW'(i))           sel_b[i] <= wr_data;
        if (wr_addr == AW'(EN_BASE + i)) en_b[i]  <= wr_data;
      end
      if (wr_addr == AW'(IDLE_ADDR)) idle_q <= wr_data;
      if (wr_addr == AW'(MODE_ADDR)) mode_q <= wr_data[0];
    end
  end

  // code bank: plain write port, asynchronous read, no reset
  always_ff @(posedge clk) begin
    if (code_hit) code_mem[wr_addr[CHW-1:0]] <= wr_data;
  end

  assign code_rd = code_mem[rd_ch];

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign sel_map[g*DW +: DW] = sel_b[g];
    assign en_map[g*DW +: DW]  = en_b[g];
  end

  assign idle_code = idle_q;
  assign loop_mode = mode_q;

  // R2: a write to select byte 0 shows up on channels 1..8 next cycle
  a_r2_sel_lane0: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == '0) |=> (sel_map[DW-1:0] == $past(wr_data)));
endmodule

// File: rtl/e1ts_select.sv
module e1ts_select
  import e1ts_pkg::*;
#(
  parameter int NCH = 32,
  parameter int DW  = 8,
  parameter int CHW = $clog2(NCH),
  parameter int BW  = $clog2(DW)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           slot_start,
  input  logic [CHW-1:0] ch_idx,
  input  logic [BW-1:0]  bit_idx,
  input  logic [NCH-1:0] sel_map,
  input  logic [NCH-1:0] en_map,
  input  logic [DW-1:0]  idle_code,
  input  logic           loop_mode,
  input  logic [DW-1:0]  code_rd,
  input  logic           bp_ser,
  input  logic           rx_ser,
  output logic           tx_ser
);
  localparam logic [BW-1:0] TOP_BIT = BW'(DW - 1);

  src_e          live_src, sh_src, src_eff;
  logic [DW-1:0] live_code, sh_code, code_eff;
  logic          tx_d, tx_q;

  always_comb begin
    live_code = idle_code;
    if (en_map[ch_idx]) begin
      live_src  = SRC_CODE;
      live_code = code_rd;
    end else if (sel_map[ch_idx]) begin
      live_src = loop_mode ? SRC_RX : SRC_CODE;
    end else begin
      live_src = SRC_BP;
    end
  end

  assign src_eff  = slot_start ? live_src  : sh_src;
  assign code_eff = slot_start ? live_code : sh_code;

  always_comb begin
    case (src_eff)
      SRC_CODE: tx_d = code_eff[TOP_BIT - bit_idx];
      SRC_RX:   tx_d = rx_ser;
      default:  tx_d = bp_ser;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_src  <= SRC_BP;
      sh_code <= '0;
      tx_q    <= 1'b0;
    end else begin
      if (slot_start) begin
        sh_src  <= live_src;
        sh_code <= live_code;
      end
      tx_q <= tx_d;
    end
  end

  assign tx_ser = tx_q;

  // R1: reset clears the line output
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (tx_q == 1'b0));
  // R9: backplane bits come out one clock later
  a_r9_bp_latency: assert property (@(posedge clk) disable iff (rst)
    (src_eff == SRC_BP) |=> (tx_q == $past(bp_ser)));
  // R4: looped-back bits come out one clock later
  a_r4_rx_latency: assert property (@(posedge clk) disable iff (rst)
    (src_eff == SRC_RX) |=> (tx_q == $past(rx_ser)));
  // R8: source does not change inside a timeslot
  a_r8_src_hold: assert property (@(posedge clk) disable iff (rst)
    (!slot_start && !$past(rst)) |-> (src_eff == $past(src_eff)));
endmodule

// File: rtl/e1_ts_insert.sv
module e1_ts_insert #(
  parameter int NCH       = 32,
  parameter int SLOT_BITS = 8,
  parameter int ADDR_W    = $clog2(NCH) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fsync,
  input  logic                 bp_ser,
  input  logic                 rx_ser,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [SLOT_BITS-1:0] wr_data,
  output logic                 tx_ser
);
  localparam int CHW = $clog2(NCH);
  localparam int BW  = $clog2(SLOT_BITS);

  logic [CHW-1:0]       ch_idx;
  logic [BW-1:0]        bit_idx;
  logic                 slot_start;
  logic [NCH-1:0]       sel_map, en_map;
  logic [SLOT_BITS-1:0] idle_code, code_rd;
  logic                 loop_mode;

  e1ts_timing #(.NCH(NCH), .SLOT_BITS(SLOT_BITS)) timing_i (
    .clk(clk), .rst(rst), .fsync(fsync),
    .ch_idx(ch_idx), .bit_idx(bit_idx), .slot_start(slot_start)
  );

  e1ts_regfile #(.NCH(NCH), .DW(SLOT_BITS), .AW(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_ch(ch_idx), .sel_map(sel_map), .en_map(en_map),
    .idle_code(idle_code), .loop_mode(loop_mode), .code_rd(code_rd)
  );

  e1ts_select #(.NCH(NCH), .DW(SLOT_BITS)) sel_i (
    .clk(clk), .rst(rst), .slot_start(slot_start), .ch_idx(ch_idx), .bit_idx(bit_idx),
    .sel_map(sel_map), .en_map(en_map), .idle_code(idle_code), .loop_mode(loop_mode),
    .code_rd(code_rd), .bp_ser(bp_ser), .rx_ser(rx_ser), .tx_ser(tx_ser)
  );
endmodule

// File: tb/e1_ts_insert_tb_top.sv
`timescale 1ns/1ps
module e1_ts_insert_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1, fsync = 1'b0, bp_ser = 1'b0, rx_ser = 1'b0, wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic tx_ser;

  always #2.5 clk = ~clk;

  e1_ts_insert dut_i (
    .clk(clk), .rst(rst), .fsync(fsync), .bp_ser(bp_ser), .rx_ser(rx_ser),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .tx_ser(tx_ser)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string tag = "R1";
  bit done = 0;

  // stimulus controls
  bit s_rst = 1, s_force = 0, auto_sync = 1, s_wr = 0;
  int s_addr = 0;
  bit [7:0] s_data = 0;

  // reference model
  int m_cnt = 255;
  bit [31:0] m_sel = 0, m_en = 0;
  bit [7:0] m_idle = 0, s_code = 0;
  bit [7:0] m_code [32];
  bit m_mode = 0;
  int s_src = 0;
  bit exp_tx = 0, have_exp = 0;

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic step();
    bit fs, bp, rx;
    int pos, ch, b;
    if (have_exp) begin
      n_cmp++;
      if (tx_ser !== exp_tx) begin
        n_bad++;
        $display("FAIL %s: tx_ser=%b expected %b at cycle %0d", tag, tx_ser, exp_tx, cyc);
      end
    end
    fs = s_force || (auto_sync && m_cnt == 255);
    bp = 1'($urandom);
    rx = 1'($urandom);
    rst = s_rst; fsync = fs; bp_ser = bp; rx_ser = rx;
    wr_en = s_wr; wr_addr = 6'(s_addr); wr_data = s_data;
    if (s_rst) begin
      m_cnt = 255; m_sel = 0; m_en = 0; m_idle = 0; m_mode = 0; s_src = 0;
      exp_tx = 0;
    end else begin
      pos = fs ? 0 : (m_cnt + 1) % 256;
      ch = pos / 8;
      b = pos % 8;
      if (b == 0) begin
        if (m_en[ch]) begin s_src = 1; s_code = m_code[ch]; end
        else if (m_sel[ch]) begin s_src = m_mode ? 2 : 1; s_code = m_idle; end
        else s_src = 0;
      end
      exp_tx = (s_src == 0) ? bp : (s_src == 2) ? rx : s_code[7-b];
      m_cnt = pos;
      if (s_wr) begin
        if (s_addr < 4)       m_sel[s_addr*8 +: 8] = s_data;
        else if (s_addr < 8)  m_en[(s_addr-4)*8 +: 8] = s_data;
        else if (s_addr == 8) m_idle = s_data;
        else if (s_addr == 9) m_mode = s_data[0];
        else if (s_addr >= 32) m_code[s_addr-32] = s_data;
      end
    end
    have_exp = 1;
    cyc++;
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(int a, bit [7:0] d);
    s_wr = 1; s_addr = a; s_data = d;
    step();
    s_wr = 0;
  endtask

  // wait until the next driven cycle will be bit k of a timeslot
  task automatic align(int k);
    while (((m_cnt + 1) % 8) != k) step();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      report();
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) m_code[i] = 0;
    @(negedge clk);
    // R1: reset state and plain pass-through
    tag = "R1";
    run(3);
    s_rst = 0;
    run(300);

    // R2, R3: idle byte into channels 1, 10, 32
    tag = "R2,R3";
    wr(8, 8'hA5);
    wr(0, 8'h01);
    wr(1, 8'h02);
    wr(3, 8'h80);
    run(520);

    // R4: loopback mode, unselected channels still pass the backplane
    tag = "R4";
    wr(9, 8'h01);
    wr(2, 8'h5A);
    run(520);

    // R5: all channels, both modes
    tag = "R5";
    for (int i = 0; i < 4; i++) wr(i, 8'hFF);
    run(300);
    wr(9, 8'h00);
    wr(8, 8'h3C);
    run(300);
    for (int i = 0; i < 4; i++) wr(i, 8'h00);
    run(260);

    // R6: per-channel codes, priority over select in both modes
    tag = "R6";
    for (int i = 0; i < 32; i++) wr(32 + i, 8'((i * 37 + 11) ^ (i << 3)));
    wr(0, 8'h0F);
    wr(4, 8'h33);
    wr(7, 8'hC0);
    wr(3, 8'h40);
    run(300);
    wr(9, 8'h01);
    run(300);

    // R7: free-running wrap without syncs, then an early sync
    tag = "R7";
    auto_sync = 0;
    run(600);
    align(5);
    s_force = 1; step(); s_force = 0;
    run(100);
    s_force = 1; step(); s_force = 0;
    auto_sync = 1;
    run(300);

    // R8: writes in the middle of a timeslot
    tag = "R8";
    wr(9, 8'h00);
    align(3);
    wr(1, 8'hFF);
    run(20);
    align(4);
    wr(8, 8'hF0);
    run(20);
    align(6);
    wr(5, 8'hFF);
    run(20);
    align(2);
    wr(40, 8'h96);
    run(300);

    // R9: alternating sources every slot keep one-clock latency
    tag = "R9";
    wr(5, 8'h00);
    wr(9, 8'h01);
    wr(0, 8'hAA); wr(1, 8'h55); wr(2, 8'hAA); wr(3, 8'h55);
    run(520);

    // R1: reset again with settings loaded, then everything passes
    tag = "R1";
    s_rst = 1; run(2); s_rst = 0;
    run(300);

    done = 1;
    report();
  end
endmodule